// File: doc/BRIEF.md
# Eight-Channel DMA Register Bank

This block holds the software-visible registers of an eight-channel peripheral DMA controller and merges the channels' completions into one interrupt line. A processor reaches it over a simple word-wide read/write bus. Each channel owns a 16-byte window. The window holds a control word, a transfer address and a transfer count. One shared status byte at the bottom of the map records which channels have finished.

The channel engines sit outside this block. They take their settings from per-channel outputs: enable, direction, mode, endpoint and burst type. They are told to launch or stop by one-cycle pulses. While a transfer runs, they write the advancing address and the remaining count back into the bank. They also flag bus errors and completions. Because the address register advances, software finds the number of bytes moved by subtracting the start address from the value it reads back. Writing zero to a control word stops that channel.

Top module: `dma_chan_regbank`

## Requirements
- R1: After reset, every register reads zero, every channel output is low, and `irq` is low.
- R2: Channel n's registers sit at byte address 16·n plus an offset: control at +0x4, address at +0x8 and count at +0xC. The interrupt status byte is at address 0x00. Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled.
- R3: The control word drives the channel outputs. Bit 0 is enable, bit 1 is transmit, bit 2 is mode 1, bit 3 is interrupt enable, bits 7:4 are the endpoint and bits 10:9 are the burst type (0 unspecified, 1 four-beat, 2 eight-beat, 3 sixteen-beat). Bits 15:11 read as zero.
- R4: A control write with bit 0 set raises `ch_start` for that channel for exactly one cycle, after the write edge, and the channel's enable is high in that cycle.
- R5: A control write whose low 16 bits are all zero raises `ch_abort` for that channel for one cycle, and the channel's enable goes low.
- R6: An engine update (`eng_upd`) loads that channel's address and count registers. In the same cycle, a bus write to one of these registers takes priority over the engine value for that register only.
- R7: An engine bus error sets control bit 8, which stays set until the next control write. Bit 8 of written data is ignored.
- R8: A completion (`eng_done`) clears the channel's enable bit. It sets the channel's status bit only when interrupt enable (control bit 3) is set.
- R9: Status bit n belongs to channel n. A read of the status byte returns it and clears it. A completion arriving in the cycle of that read is kept in the status.
- R10: `irq` is high exactly while any status bit is set.
- R11: Reads of unmapped addresses (channel offset 0 for channels 1 to 7, and anything at or above 0x80) return zero. Writes to the status byte and to unmapped addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| eng_upd | input | 8 | Per-channel address/count update valid |
| eng_addr | input | 256 | Per-channel updated address, 32 bits each |
| eng_cnt | input | 256 | Per-channel updated count, 32 bits each |
| eng_err | input | 8 | Per-channel bus error flag |
| eng_done | input | 8 | Per-channel completion pulse |
| ch_en | output | 8 | Channel enable |
| ch_tx | output | 8 | Transmit direction |
| ch_mode1 | output | 8 | Mode 1 select |
| ch_ep | output | 32 | Endpoint number, 4 bits per channel |
| ch_burst | output | 16 | Burst type, 2 bits per channel |
| ch_start | output | 8 | Launch pulse |
| ch_abort | output | 8 | Stop pulse |
| irq | output | 1 | Interrupt request |

## Verification
Register writes, engine updates and completions change the registers at the edge that samples them. So the channel outputs, the start and abort pulses and `irq` are checked just after that edge. Read data is registered, so it is due one edge after the read strobe is sampled. The scoreboard queues each expected read word when the read is issued and compares it at the falling edge that follows the next rising edge. The case where a completion and a status read arrive together is driven in a single cycle, and the retained bit is then checked with a second read.

// File: rtl/dma_chan_regbank.sv
module dma_chan_regbank #(
  parameter int NCH = 8,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NCH-1:0]    eng_upd,
  input  logic [NCH*DW-1:0] eng_addr,
  input  logic [NCH*DW-1:0] eng_cnt,
  input  logic [NCH-1:0]    eng_err,
  input  logic [NCH-1:0]    eng_done,
  output logic [NCH-1:0]    ch_en,
  output logic [NCH-1:0]    ch_tx,
  output logic [NCH-1:0]    ch_mode1,
  output logic [NCH*4-1:0]  ch_ep,
  output logic [NCH*2-1:0]  ch_burst,
  output logic [NCH-1:0]    ch_start,
  output logic [NCH-1:0]    ch_abort,
  output logic              irq
);
  localparam int CW = 11;
  localparam int WB = AW - 4;

  logic [WB-1:0] win;
  logic [1:0]    off;
  logic          win_ok;
  logic          stat_sel;
  logic [NCH-1:0] stat_q, stat_set;
  logic [NCH-1:0][CW-1:0] ctrl_v;
  logic [NCH-1:0][DW-1:0] addr_v, cnt_v;
  logic [DW-1:0] rd_mux;

  assign win      = bus_addr[AW-1:4];
  assign off      = bus_addr[3:2];
  assign win_ok   = (int'(win) < NCH);
  assign stat_sel = (bus_addr == '0);
  assign irq      = |stat_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic          hit, wr_ctrl, wr_addr, wr_cnt;
    logic [CW-1:0] c;
    logic [DW-1:0] a, n;

    assign hit     = bus_wr && win_ok && (int'(win) == i);
    assign wr_ctrl = hit && (off == 2'd1);
    assign wr_addr = hit && (off == 2'd2);
    assign wr_cnt  = hit && (off == 2'd3);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        c           <= '0;
        a           <= '0;
        n           <= '0;
        ch_start[i] <= 1'b0;
        ch_abort[i] <= 1'b0;
      end else begin
        ch_start[i] <= wr_ctrl && bus_wdata[0];
        ch_abort[i] <= wr_ctrl && (bus_wdata[15:0] == 16'h0);
        if (wr_ctrl) begin
          c <= {bus_wdata[10:9], 1'b0, bus_wdata[7:0]};
        end else begin
          if (eng_err[i])  c[8] <= 1'b1;
          if (eng_done[i]) c[0] <= 1'b0;
        end
        if (wr_addr)         a <= bus_wdata;
        else if (eng_upd[i]) a <= eng_addr[i*DW +: DW];
        if (wr_cnt)          n <= bus_wdata;
        else if (eng_upd[i]) n <= eng_cnt[i*DW +: DW];
      end
    end

    assign ctrl_v[i]        = c;
    assign addr_v[i]        = a;
    assign cnt_v[i]         = n;
    assign stat_set[i]      = eng_done[i] && c[3];
    assign ch_en[i]         = c[0];
    assign ch_tx[i]         = c[1];
    assign ch_mode1[i]      = c[2];
    assign ch_ep[i*4 +: 4]  = c[7:4];
    assign ch_burst[i*2 +: 2] = c[10:9];

    // R4
    a_r4_start_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      ch_start[i] |-> ch_en[i]);
    // R5
    a_r5_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
      ch_abort[i] |-> (!ch_en[i] && !ch_start[i]));
    // R8
    a_r8_done_disables: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done[i] && !wr_ctrl) |=> !ch_en[i]);
    // R7
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_err[i] && !wr_ctrl) |=> ctrl_v[i][8]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 stat_q <= '0;
    else if (bus_rd && stat_sel) stat_q <= stat_set;
    else                         stat_q <= stat_q | stat_set;
  end

  always_comb begin
    rd_mux = '0;
    if (stat_sel) begin
      rd_mux[NCH-1:0] = stat_q;
    end else if (win_ok) begin
      case (off)
        2'd1:    rd_mux[CW-1:0] = ctrl_v[win];
        2'd2:    rd_mux = addr_v[win];
        2'd3:    rd_mux = cnt_v[win];
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R9
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && stat_sel) |=> ((stat_q & ~$past(stat_set)) == '0));
  // R10
  a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|stat_set));
endmodule

// File: tb/sim_dma_chan_regbank.sv
module sim_dma_chan_regbank;
  localparam int NCH = 8;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] eng_upd = '0, eng_err = '0, eng_done = '0;
  logic [NCH*32-1:0] eng_addr = '0, eng_cnt = '0;
  logic [NCH-1:0] ch_en, ch_tx, ch_mode1, ch_start, ch_abort;
  logic [NCH*4-1:0] ch_ep;
  logic [NCH*2-1:0] ch_burst;
  logic irq;

  int checks = 0, errors = 0;
  bit done_flag = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit pend = 0;

  always #2 clk = ~clk;

  dma_chan_regbank u0 (.clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata,
    .bus_rdata, .eng_upd, .eng_addr, .eng_cnt, .eng_err, .eng_done, .ch_en,
    .ch_tx, .ch_mode1, .ch_ep, .ch_burst, .ch_start, .ch_abort, .irq);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) chk(32'hx, 32'h0, "scoreboard underflow");
      else chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      pend = 0;
    end
    if (bus_rd) pend = 1;
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    bus_rd = 1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_rd = 0;
  endtask

  task automatic upd(input int ch, input logic [31:0] a, input logic [31:0] c);
    @(posedge clk); #1;
    eng_upd[ch] = 1; eng_addr[ch*32 +: 32] = a; eng_cnt[ch*32 +: 32] = c;
    @(posedge clk); #1;
    eng_upd[ch] = 0;
  endtask

  task automatic done_pulse(input int ch);
    @(posedge clk); #1; eng_done[ch] = 1;
    @(posedge clk); #1; eng_done[ch] = 0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk({31'h0, irq}, 0, "R1 irq");
    chk(ch_en, 0, "R1 ch_en");
    chk(bus_rdata, 0, "R1 rdata");
    rd(8'h00, 0, "R1 status");
    rd(8'h34, 0, "R1 ctrl3");
    rd(8'h78, 0, "R1 addr7");

    // R2 R3 R4 channel 3 setup and launch
    wr(8'h38, 32'h1000);
    wr(8'h3C, 32'h200);
    wr(8'h34, 32'h065F);
    chk(ch_start[3], 1, "R4 start pulse");
    chk(ch_en[3], 1, "R3 enable");
    chk(ch_tx[3], 1, "R3 tx");
    chk(ch_mode1[3], 1, "R3 mode1");
    chk(ch_ep[12 +: 4], 5, "R3 endpoint");
    chk(ch_burst[6 +: 2], 3, "R3 burst");
    @(posedge clk); #1;
    chk(ch_start[3], 0, "R4 pulse width");
    rd(8'h34, 32'h065F, "R2 ctrl3 readback");
    rd(8'h38, 32'h1000, "R2 addr3");
    rd(8'h3C, 32'h200, "R2 count3");
    wr(8'h64, 32'hFFFF_F800);
    rd(8'h64, 0, "R3 upper ctrl bits zero");

    // R6 engine progress
    upd(3, 32'h1040, 32'h1C0);
    rd(8'h38, 32'h1040, "R6 addr advanced");
    rd(8'h3C, 32'h1C0, "R6 count updated");

    // R8 R9 R10 completion with interrupt enable
    done_pulse(3);
    chk(ch_en[3], 0, "R8 done clears enable");
    chk(irq, 1, "R10 irq high");
    rd(8'h00, 32'h08, "R9 status bit3");
    chk(irq, 0, "R10 irq low after read");
    rd(8'h00, 0, "R9 cleared");

    // R8 no interrupt enable
    wr(8'h54, 32'h0001);
    done_pulse(5);
    chk(ch_en[5], 0, "R8 ch5 disabled");
    chk(irq, 0, "R8 no irq without ie");
    rd(8'h00, 0, "R8 status empty");

    // R9 completion concurrent with read
    wr(8'h14, 32'h0009);
    @(posedge clk); #1;
    bus_rd = 1; bus_addr = 8'h00; eng_done[1] = 1;
    exp_q.push_back(0); tag_q.push_back("R9 concurrent read old value");
    @(posedge clk); #1;
    bus_rd = 0; eng_done[1] = 0;
    chk(irq, 1, "R9 concurrent bit kept irq");
    rd(8'h00, 32'h02, "R9 concurrent bit kept");

    // R7 bus error
    wr(8'h24, 32'h0001);
    @(posedge clk); #1; eng_err[2] = 1;
    @(posedge clk); #1; eng_err[2] = 0;
    rd(8'h24, 32'h0101, "R7 error flag set");
    wr(8'h24, 32'h0103);
    rd(8'h24, 32'h0003, "R7 error cleared, write ignored");

    // R5 abort
    wr(8'h24, 32'h0000);
    chk(ch_abort[2], 1, "R5 abort pulse");
    chk(ch_en[2], 0, "R5 enable low");
    @(posedge clk); #1;
    chk(ch_abort[2], 0, "R5 abort width");
    wr(8'h28, 0);
    wr(8'h2C, 0);
    rd(8'h28, 0, "R5 addr zeroed");

    // R6 priority
    @(posedge clk); #1;
    bus_wr = 1; bus_addr = 8'h48; bus_wdata = 32'hAAAA0000;
    eng_upd[4] = 1; eng_addr[4*32 +: 32] = 32'h5555; eng_cnt[4*32 +: 32] = 32'h77;
    @(posedge clk); #1;
    bus_wr = 0; eng_upd[4] = 0;
    rd(8'h48, 32'hAAAA0000, "R6 bus wins addr");
    rd(8'h4C, 32'h77, "R6 engine count");

    // R11 unmapped
    rd(8'h84, 0, "R11 above map");
    rd(8'h10, 0, "R11 ch1 offset0");
    wr(8'h90, 32'h1234);
    wr(8'h00, 32'hFF);
    chk(irq, 0, "R11 status write ignored irq");
    rd(8'h00, 0, "R11 status write ignored");

    repeat (3) @(posedge clk);
    chk(exp_q.size(), 0, "scoreboard drained");
    finish_run();
  end
endmodule